// File: doc/BRIEF.md
# Sequential PWM Turn-Indicator Sequencer

This block lights four PWM lamp channels one after another to make a sweeping turn-indicator pattern. A sequence starts on a rising edge of the trigger input. It also starts by itself in the first clock cycle after reset is released, so a power-up alone runs the sweep. Channel 0 waits for its own start delay. Each later channel waits one shared delay after the channel before it. A channel that has begun brightens along a geometric (logarithmic-looking) curve, from the programmed low duty to the programmed high duty, and then stays lit.

The sweep can be chained across several devices. One shared delay after the last channel begins, the trigger output changes level, and the next device starts its own sweep from that edge. All delays are counted in step intervals, and the fade-rate word sets the length of one step interval. A fade rate of zero turns fading off: each channel jumps straight to the high duty, while the delays keep running on a fixed 256-cycle interval.

The configuration words are static levels. They are meant to be changed only while no sequence is running. Every PWM output uses a 128-count duty counter, slowed by a power-of-two prescaler. A new duty value is picked up only at a period boundary, so no pulse is ever cut short or stretched partway through a period.

Top module: `turn_seq`

## Requirements
- R1: While reset is asserted, all lamp outputs and `trig_out` are 0.
- R2: A sequence starts on the clock edge that first samples `trig_in` high after it was low. A sequence also starts on the first clock edge after reset is released. On every start, `trig_out` keeps its current level until the sequence completes.
- R3: Let X be the starting edge, I the step interval, D0 = `first_delay` and Dc = `common_delay`. Channel k begins on edge X + (D0 + k·Dc)·I + k + 1. `trig_out` inverts on edge X + (D0 + 4·Dc)·I + 5.
- R4: I equals `fade_rate` when that word is non-zero, and 256 when it is zero.
- R5: With fading on, a channel starts at `duty_lo`. Every I cycles its duty d becomes d + max(1, d>>3). The duty is clamped at `duty_hi`, and it never decreases while the channel is lit.
- R6: With `fade_rate` = 0, a channel's duty equals `duty_hi` from the cycle after the channel begins.
- R7: A channel that has not begun in the current sequence holds `duty_lo`. A lit channel stays at `duty_hi` until the next start, because there is no fade-out.
- R8: Let S = `period_sel`. The PWM period is 128·2^S cycles. In each period the output is high for duty·2^S cycles, starting at the start of the period. The displayed duty changes only at a period boundary.
- R9: A start while a sequence is running returns every channel to not-begun at `duty_lo` and restarts the timing of R3 from the new starting edge.
- R10: Channels begin in ascending index order. Channel k is never lit while channel k-1 is dark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_in | input | 1 | Start request; a rising edge starts a sequence |
| duty_lo | input | 7 | Duty held before a channel begins, and the start of its fade |
| duty_hi | input | 7 | Final duty of every channel |
| fade_rate | input | 16 | Step interval in cycles; 0 turns fading off and selects a 256-cycle interval |
| first_delay | input | 16 | Channel 0 start delay, in step intervals |
| common_delay | input | 16 | Delay between later channels and before `trig_out`, in step intervals |
| period_sel | input | 5 | PWM prescale exponent |
| lamp_pwm | output | 4 | PWM outputs, bit k drives channel k |
| trig_out | output | 1 | Inverts when a sweep completes, to start the next device |

## Verification
The assertions assume that `duty_lo` is not greater than `duty_hi`. They also assume that the configuration words hold still while a sequence runs, since the monotonic-fade and jump checks compare a duty against the high limit in force in that cycle. The stimulus applies every configuration change between sequences, and it draws random low and high duties such that the high duty always exceeds the low duty by at least five. Random delays include zero, and random rates stay small, so that each run of the sweep fits inside the bench's cycle budget.

// File: rtl/turn_seq_pkg.sv
package turn_seq_pkg;
  // Step interval used for delays when fading is switched off
  localparam int unsigned OFF_INTERVAL = 256;
  // Geometric growth: d += d >> GROW_SHIFT (at least 1) per step
  localparam int GROW_SHIFT = 3;
endpackage

// File: rtl/turn_seq_ctrl.sv
module turn_seq_ctrl #(
  parameter int NCH   = 4,
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [CFG_W-1:0] rate,
  input  logic [CFG_W-1:0] d_first,
  input  logic [CFG_W-1:0] d_common,
  output logic             start,
  output logic [NCH-1:0]   go,
  output logic             fade_tick,
  output logic             fade_en,
  output logic             trig_out
);
  import turn_seq_pkg::*;
  localparam int PH_W = $clog2(NCH + 1);
  localparam int IV_W = (CFG_W > 9) ? CFG_W : 9;

  logic             boot, trig_q, running, fire;
  logic [PH_W-1:0]  phase;
  logic [CFG_W-1:0] rem;
  logic [IV_W-1:0]  stc, ftc, last;

  always_comb begin
    last = ((rate == '0) ? IV_W'(OFF_INTERVAL) : IV_W'(rate)) - IV_W'(1);
  end

  assign start     = boot | (trig & ~trig_q);
  assign fire      = running && (rem == '0);
  assign fade_en   = (rate != '0);
  assign fade_tick = (ftc >= last) && !start;

  for (genvar k = 0; k < NCH; k++) begin : g_go
    assign go[k] = fire && !start && (phase == PH_W'(k));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot     <= 1'b1;
      trig_q   <= 1'b0;
      running  <= 1'b0;
      phase    <= '0;
      rem      <= '0;
      stc      <= '0;
      ftc      <= '0;
      trig_out <= 1'b0;
    end else begin
      boot   <= 1'b0;
      trig_q <= trig;
      if (start) begin
        running <= 1'b1;
        phase   <= '0;
        rem     <= d_first;
        stc     <= '0;
        ftc     <= '0;
      end else begin
        ftc <= (ftc >= last) ? '0 : ftc + IV_W'(1);
        if (fire) begin
          if (phase == PH_W'(NCH)) begin
            running  <= 1'b0;
            trig_out <= ~trig_out;
          end else begin
            phase <= phase + PH_W'(1);
            rem   <= d_common;
            stc   <= '0;
          end
        end else if (running) begin
          if (stc >= last) begin
            stc <= '0;
            rem <= rem - CFG_W'(1);
          end else begin
            stc <= stc + IV_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/turn_seq_pwmbase.sv
module turn_seq_pwmbase #(
  parameter int DUTY_W = 7,
  parameter int FSEL_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FSEL_W-1:0] fsel,
  output logic [DUTY_W-1:0] cnt,
  output logic              boundary
);
  localparam int PRE_W = 1 << FSEL_W;

  logic [PRE_W-1:0] pre, limit;
  logic             adv;

  assign limit    = (PRE_W'(1) << fsel) - PRE_W'(1);
  assign adv      = (pre >= limit);
  assign boundary = adv && (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      cnt <= '0;
    end else if (adv) begin
      pre <= '0;
      cnt <= cnt + DUTY_W'(1);
    end else begin
      pre <= pre + PRE_W'(1);
    end
  end
endmodule

// File: rtl/turn_seq_lamp.sv
module turn_seq_lamp #(
  parameter int DUTY_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              go,
  input  logic              fade_tick,
  input  logic              fade_en,
  input  logic [DUTY_W-1:0] dmin,
  input  logic [DUTY_W-1:0] dmax,
  input  logic              boundary,
  input  logic [DUTY_W-1:0] cnt,
  output logic              active,
  output logic [DUTY_W-1:0] duty,
  output logic [DUTY_W-1:0] shown,
  output logic              pwm
);
  import turn_seq_pkg::*;

  logic [DUTY_W-1:0] inc;
  logic [DUTY_W:0]   sum;

  always_comb begin
    inc = duty >> GROW_SHIFT;
    if (inc == '0) inc = DUTY_W'(1);
    sum = {1'b0, duty} + {1'b0, inc};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      duty   <= '0;
      shown  <= '0;
    end else begin
      if (boundary) shown <= duty;
      if (start) begin
        active <= 1'b0;
        duty   <= dmin;
      end else if (go) begin
        active <= 1'b1;
        duty   <= fade_en ? dmin : dmax;
      end else if (!active) begin
        duty <= dmin;
      end else if (duty >= dmax) begin
        duty <= dmax;
      end else if (fade_en && fade_tick) begin
        duty <= (sum >= {1'b0, dmax}) ? dmax : sum[DUTY_W-1:0];
      end
    end
  end

  assign pwm = (cnt < shown);
endmodule

// File: rtl/turn_seq.sv
module turn_seq #(
  parameter int NCH    = 4,
  parameter int DUTY_W = 7,
  parameter int CFG_W  = 16,
  parameter int FSEL_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_in,
  input  logic [DUTY_W-1:0] duty_lo,
  input  logic [DUTY_W-1:0] duty_hi,
  input  logic [CFG_W-1:0]  fade_rate,
  input  logic [CFG_W-1:0]  first_delay,
  input  logic [CFG_W-1:0]  common_delay,
  input  logic [FSEL_W-1:0] period_sel,
  output logic [NCH-1:0]    lamp_pwm,
  output logic              trig_out
);
  logic                         start, fade_tick, fade_en, boundary;
  logic [NCH-1:0]               go, active_v;
  logic [DUTY_W-1:0]            cnt;
  logic [NCH-1:0][DUTY_W-1:0]   duty_v, shown_v;

  turn_seq_ctrl #(.NCH(NCH), .CFG_W(CFG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .trig(trig_in), .rate(fade_rate),
    .d_first(first_delay), .d_common(common_delay), .start(start),
    .go(go), .fade_tick(fade_tick), .fade_en(fade_en), .trig_out(trig_out)
  );

  turn_seq_pwmbase #(.DUTY_W(DUTY_W), .FSEL_W(FSEL_W)) u_base (
    .clk(clk), .rst_n(rst_n), .fsel(period_sel), .cnt(cnt), .boundary(boundary)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_lamp
    turn_seq_lamp #(.DUTY_W(DUTY_W)) u_lamp (
      .clk(clk), .rst_n(rst_n), .start(start), .go(go[k]),
      .fade_tick(fade_tick), .fade_en(fade_en), .dmin(duty_lo),
      .dmax(duty_hi), .boundary(boundary), .cnt(cnt),
      .active(active_v[k]), .duty(duty_v[k]), .shown(shown_v[k]),
      .pwm(lamp_pwm[k])
    );
  end
endmodule

// File: rtl/turn_seq_chk.sv
module turn_seq_chk #(
  parameter int NCH    = 4,
  parameter int DUTY_W = 7
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       start,
  input logic [NCH-1:0]             go,
  input logic                       fade_en,
  input logic [NCH-1:0]             active_v,
  input logic [NCH-1:0][DUTY_W-1:0] duty_v,
  input logic [NCH-1:0][DUTY_W-1:0] shown_v,
  input logic                       boundary,
  input logic                       trig_out,
  input logic [DUTY_W-1:0]          dmax
);
  // R10: lit channels always form a contiguous run from channel 0
  p_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (NCH'(active_v + NCH'(1)) & active_v) == '0);

  // R9: a start darkens every channel
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (active_v == '0));

  // R8: displayed duty only moves at a period boundary
  p_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(shown_v));

  // R3: the chain output only moves once every channel has begun
  p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(trig_out) |-> (&active_v));

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    // R5: a lit channel never dims below its previous duty
    p_fade_mono_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (active_v[k] && !start && duty_v[k] <= dmax) |=> duty_v[k] >= $past(duty_v[k]));
    // R6: with fading off a channel lands on the high duty at once
    p_jump_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (go[k] && !fade_en && !start) |=> duty_v[k] == $past(dmax));
  end
endmodule

bind turn_seq turn_seq_chk #(.NCH(NCH), .DUTY_W(DUTY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .go(go), .fade_en(fade_en),
  .active_v(active_v), .duty_v(duty_v), .shown_v(shown_v),
  .boundary(boundary), .trig_out(trig_out), .dmax(duty_hi)
);

// File: tb/tb_turn_seq.sv
module tb_turn_seq;
  localparam int NCH = 4;

  logic clk = 1'b0, rst_n = 1'b0, trig_in = 1'b0;
  logic [6:0]  duty_lo, duty_hi;
  logic [15:0] fade_rate, first_delay, common_delay;
  logic [4:0]  period_sel;
  logic [NCH-1:0] lamp_pwm;
  logic trig_out;
  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  turn_seq dut (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .duty_lo(duty_lo),
    .duty_hi(duty_hi), .fade_rate(fade_rate), .first_delay(first_delay),
    .common_delay(common_delay), .period_sel(period_sel),
    .lamp_pwm(lamp_pwm), .trig_out(trig_out)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic setcfg(input int lo, input int hi, input int rate,
                        input int d0, input int dc, input int fs);
    duty_lo = 7'(lo); duty_hi = 7'(hi); fade_rate = 16'(rate);
    first_delay = 16'(d0); common_delay = 16'(dc); period_sel = 5'(fs);
  endtask

  function automatic int iv_of(input int rate);
    return (rate == 0) ? 256 : rate;
  endfunction

  // R3: edges from starting edge to trig_out change, +1 for negedge sampling
  function automatic int exp_toggle(input int rate, input int d0, input int dc);
    return (d0 + NCH * dc) * iv_of(rate) + 6;
  endfunction

  // R5: is v a duty value on the fade curve from lo to hi
  function automatic bit on_curve(input int v, input int lo, input int hi);
    int d = lo;
    if (v == hi) return 1'b1;
    while (d < hi) begin
      int inc;
      if (d == v) return 1'b1;
      inc = d >> 3;
      if (inc == 0) inc = 1;
      d = d + inc;
    end
    return 1'b0;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure_high(input int ch, output int hi);
    int per = 128 << period_sel;
    int t = 0;
    hi = 0;
    while (lamp_pwm[ch] && t < 2 * per) begin @(negedge clk); t++; end
    t = 0;
    while (!lamp_pwm[ch] && t < 2 * per) begin @(negedge clk); t++; end
    while (lamp_pwm[ch] && hi < 2 * per) begin @(negedge clk); hi++; end
  endtask

  // Pulse trig_in (when pulse=1) and count negedges until trig_out moves
  task automatic time_toggle(input bit pulse, input int lim, output int n);
    logic old = trig_out;
    n = 0;
    if (pulse) trig_in = 1'b1;
    while (trig_out == old && n < lim) begin
      @(negedge clk);
      trig_in = 1'b0;
      n++;
    end
  endtask

  task automatic pulse_trig;
    trig_in = 1'b1;
    @(negedge clk);
    trig_in = 1'b0;
  endtask

  task automatic all_at_max(input string tag);
    for (int c = 0; c < NCH; c++) begin
      int h;
      measure_high(c, h);
      chk(tag, h, int'(duty_hi) << period_sel);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int n, h, prev, mids;
    int lo, hi, rate, d0, dc, fs;
    void'($urandom(32'd20240611));

    // R1: reset state
    setcfg(3, 90, 4, 3, 2, 0);
    idle(3);
    chk("R1 pwm in reset", lamp_pwm, 0);
    chk("R1 trig_out in reset", trig_out, 0);

    // R2 power-up start and R3 timing from reset release
    rst_n = 1'b1;
    time_toggle(1'b0, exp_toggle(4, 3, 2) + 50, n);
    chk("R2 R3 power-up toggle edge", n, exp_toggle(4, 3, 2));
    idle(130 * 4 + 256);
    all_at_max("R7 R8 lit at high duty");
    idle(1500);
    measure_high(0, h);
    chk("R7 no fade-out", h, 90);

    // R6 and R4: fading off, delays on the 256 interval
    setcfg(10, 77, 0, 1, 4, 0);
    idle(2);
    pulse_trig();
    idle(455);
    measure_high(0, h);
    chk("R6 jump to high duty", h, 77);
    measure_high(3, h);
    chk("R7 not-begun channel at low duty", h, 10);
    time_toggle(1'b1, exp_toggle(0, 1, 4) + 50, n);
    chk("R4 R9 toggle with 256 interval", n, exp_toggle(0, 1, 4));

    // R5 curve shape and R10 ordering
    setcfg(2, 120, 400, 0, 40, 0);
    idle(2);
    pulse_trig();
    idle(130);
    measure_high(1, h);
    chk("R10 later channel still dark at low duty", h, 2);
    prev = 0; mids = 0;
    for (int s = 0; s < 150; s++) begin
      measure_high(0, h);
      chk("R5 duty on fade curve", on_curve(h, 2, 120), 1);
      chk("R5 duty non-decreasing", (h >= prev), 1);
      if (h > 2 && h < 120) mids++;
      prev = h;
      if (h == 120) break;
    end
    chk("R5 reached high duty", prev, 120);
    chk("R5 passed intermediate steps", (mids >= 10), 1);

    // R9 retrigger mid-sequence restarts timing
    setcfg(4, 60, 10, 40, 5, 0);
    idle(2);
    n = int'(trig_out);
    pulse_trig();
    idle(579);
    chk("R9 no toggle before restart", trig_out, n);
    time_toggle(1'b1, exp_toggle(10, 40, 5) + 50, n);
    chk("R9 toggle timed from retrigger", n, exp_toggle(10, 40, 5));
    idle(130 * 10 + 256);
    pulse_trig();
    idle(2);
    measure_high(3, h);
    chk("R9 R7 restart returns channel to low duty", h, 4);
    idle(700);

    // Random configurations: R3 timing, R8 prescale, R7 final level
    for (int it = 0; it < 8; it++) begin
      fs = $urandom_range(0, 1);
      lo = $urandom_range(1, 30);
      hi = lo + $urandom_range(5, 60);
      rate = $urandom_range(1, 24);
      d0 = $urandom_range(0, 6);
      dc = $urandom_range(0, 6);
      setcfg(lo, hi, rate, d0, dc, fs);
      idle(2);
      time_toggle(1'b1, exp_toggle(rate, d0, dc) + 50, n);
      chk("R3 random toggle edge", n, exp_toggle(rate, d0, dc));
      idle(130 * rate + (256 << fs));
      all_at_max("R8 random high time");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule